// File: doc/BRIEF.md
# Triggered Dual-Channel Record Capture

This block takes two ADC channels that are sampled at the same instant and cuts fixed-length records out of them. Each record begins on an external trigger edge. Both channels present a 16-bit sample on every cycle in which a shared valid strobe is high. Once a record has begun, the block accepts exactly `rec_len` sample pairs. It then waits for the next trigger.

Inside one channel, four consecutive samples are packed into a 64-bit word. Each completed group produces a pair of words, one per channel. These go into a small pair buffer that drains through a valid/ready stream towards a host-bound FIFO. Every word carries a channel tag, and the final word of each channel in a record is marked.

A session is armed with `start`. Completed records are counted against `rec_total`, and the block raises `done` when the count reaches it. Triggers that arrive in the middle of a record are counted as missed. Buffer exhaustion sets a sticky overflow flag.

Top module: `trig_rec_capture`

## Requirements
- R1: After reset, `m_valid`, `done` and `ovf` are 0, `rec_count` and `miss_count` are 0, and the block stays unarmed until `start` is pulsed.
- R2: `trig_in` is asynchronous. When the block is armed and not capturing, a rising edge starts one record. A level held high starts only one record. Triggers seen before the first `start` are ignored.
- R3: `rec_len` must be a nonzero multiple of 4. A record takes exactly `rec_len` samples per channel, and only in cycles where `smp_valid` is 1. Samples outside a record produce no output.
- R4: Within a word, the earliest of four consecutive samples sits in bits [15:0]. Each later sample goes 16 bits higher, so the fourth sample is in bits [63:48].
- R5: `m_chan` is 0 for words from `smp_ch0` and 1 for words from `smp_ch1`. For every group of four samples, the channel 0 word is delivered first and the channel 1 word follows. `m_last` is 1 only on each channel's final word of a record.
- R6: A word transfers on a cycle where both `m_valid` and `m_ready` are 1. While `m_valid` is 1 and `m_ready` is 0, `m_data`, `m_chan` and `m_last` hold steady.
- R7: A trigger edge that arrives during a record does not restart the record. Each such edge adds 1 to `miss_count`, which saturates at its maximum.
- R8: `rec_count` rises by 1 per completed record. `done` goes to 1 when `rec_count` reaches `rec_total` (which must be at least 1). While `done` is 1, triggers start nothing and are not counted. A `start` pulse clears `rec_count`, `miss_count` and `done` and re-arms the block.
- R9: The buffer holds `BUF_DEPTH` word pairs. If a pair completes while the buffer is full, `ovf` goes to 1 and stays there. That pair and every later pair are discarded until `ovf_clr` is pulsed. Pairs that were already buffered are still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: arm a new session, clear counters and done |
| ovf_clr | input | 1 | Pulse: clear the sticky overflow flag |
| rec_len | input | REC_LEN_W | Samples per channel per record |
| rec_total | input | REC_CNT_W | Records per session |
| trig_in | input | 1 | Asynchronous record trigger |
| smp_valid | input | 1 | Both channel samples valid this cycle |
| smp_ch0 | input | 16 | Channel 0 sample |
| smp_ch1 | input | 16 | Channel 1 sample |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 64 | Four packed samples |
| m_chan | output | 1 | Channel tag of the word |
| m_last | output | 1 | Final word of the record for this channel |
| done | output | 1 | Session record total reached |
| ovf | output | 1 | Sticky overflow flag |
| rec_count | output | REC_CNT_W | Completed records in this session |
| miss_count | output | MISS_W | Triggers that arrived during a record |

## Verification
A sample counter that has drifted shows up within one record. The words for that record come out too many or too few, or `m_last` lands on the wrong word, and this is visible as soon as the buffer drains. A lane index or buffer pointer that is out of step shows immediately in the next delivered word: samples appear in the wrong order, or the channel tags stop alternating. Session state faults show at `rec_count`, `done` and `miss_count` right after the record or trigger edge concerned. Overflow faults show at `ovf`, and in the number of words that arrive after the buffer is exhausted.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;

    localparam int SMP_W      = 16;
    localparam int LANES      = 4;
    localparam int WORD_W     = SMP_W * LANES;
    localparam int NCH        = 2;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef logic [SMP_W-1:0]  smp_t;
    typedef logic [WORD_W-1:0] word_data_t;

    // One packed output word plus its end-of-record marker.
    typedef struct packed {
        logic       last;
        word_data_t data;
    } out_word_t;

    // Words of all channels completed in the same cycle.
    typedef struct packed {
        out_word_t [NCH-1:0] w;
    } word_pair_t;

    typedef enum logic [1:0] {
        ST_UNARMED,
        ST_ARMED,
        ST_CAPTURE,
        ST_DONE
    } cap_state_e;

endpackage

// File: rtl/trc_trig_edge.sv
`timescale 1ns/1ps
// Synchroniser chain followed by a rising-edge detector (R2).
module trc_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/trc_packer.sv
`timescale 1ns/1ps
// Gathers LANES samples of one channel into one word, earliest in the low lane (R4).
module trc_packer
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      accept,
    input  logic      last_in,
    input  smp_t      smp,
    output logic      word_vld,
    output out_word_t word_o
);

    localparam int PART_W = SMP_W * (LANES - 1);

    logic [LANE_IDX_W-1:0] lane_q;
    logic [PART_W-1:0]     part_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q   <= '0;
            part_q   <= '0;
            word_vld <= 1'b0;
            word_o   <= '0;
        end else begin
            word_vld <= 1'b0;
            if (clear) begin
                lane_q <= '0;
            end else if (accept) begin
                if (lane_q == LANE_IDX_W'(LANES - 1)) begin
                    word_o.data <= {smp, part_q};
                    word_o.last <= last_in;
                    word_vld    <= 1'b1;
                    lane_q      <= '0;
                end else begin
                    for (int i = 0; i < LANES - 1; i++) begin
                        if (lane_q == LANE_IDX_W'(i)) begin
                            part_q[i*SMP_W +: SMP_W] <= smp;
                        end
                    end
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trc_pair_buf.sv
`timescale 1ns/1ps
// Word-pair buffer that serialises each pair as channel 0 then channel 1 (R5, R6),
// with sticky overflow and drop-until-clear behaviour (R9).
module trc_pair_buf
    import trc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  word_pair_t        pair_in,
    input  logic              ovf_clr,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [WORD_W-1:0] m_data,
    output logic              m_chan,
    output logic              m_last,
    output logic              ovf
);

    localparam int AW = $clog2(DEPTH);

    word_pair_t    mem [DEPTH];
    logic [AW-1:0] wr_q;
    logic [AW-1:0] rd_q;
    logic [AW:0]   cnt_q;
    logic          sel_q;
    logic          ovf_q;
    logic          full;
    logic          wr_en;
    logic          xfer;
    logic          pop;
    out_word_t     head;

    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign wr_en = push & ~full & ~ovf_q;
    assign xfer  = m_valid & m_ready;
    assign pop   = xfer & sel_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_q] <= pair_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            sel_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_en) wr_q <= wr_q + 1'b1;
            if (pop)   rd_q <= rd_q + 1'b1;
            case ({wr_en, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (xfer) sel_q <= ~sel_q;
            if (ovf_clr) begin
                ovf_q <= 1'b0;
            end else if (push && !wr_en) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign head    = mem[rd_q].w[sel_q];
    assign m_valid = (cnt_q != '0);
    assign m_data  = head.data;
    assign m_last  = head.last;
    assign m_chan  = sel_q;
    assign ovf     = ovf_q;

endmodule

// File: rtl/trig_rec_capture.sv
`timescale 1ns/1ps
// Triggered fixed-length record capture for two simultaneously sampled channels.
module trig_rec_capture
    import trc_pkg::*;
#(
    parameter int REC_LEN_W   = 16,
    parameter int REC_CNT_W   = 20,
    parameter int MISS_W      = 16,
    parameter int BUF_DEPTH   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 ovf_clr,
    input  logic [REC_LEN_W-1:0] rec_len,
    input  logic [REC_CNT_W-1:0] rec_total,
    input  logic                 trig_in,
    input  logic                 smp_valid,
    input  logic [15:0]          smp_ch0,
    input  logic [15:0]          smp_ch1,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [63:0]          m_data,
    output logic                 m_chan,
    output logic                 m_last,
    output logic                 done,
    output logic                 ovf,
    output logic [REC_CNT_W-1:0] rec_count,
    output logic [MISS_W-1:0]    miss_count
);

    cap_state_e           state_q;
    logic [REC_LEN_W-1:0] smp_cnt_q;
    logic [REC_CNT_W-1:0] rec_cnt_q;
    logic [MISS_W-1:0]    miss_q;
    logic                 trig_rise;
    logic                 accept;
    logic                 last_smp;
    logic                 pack_clr;
    logic [REC_CNT_W-1:0] rec_cnt_next;
    smp_t [NCH-1:0]       smp_arr;
    logic [NCH-1:0]       word_vld;
    word_pair_t           pair;

    trc_trig_edge #(.STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_in),
        .rise       (trig_rise)
    );

    assign accept       = (state_q == ST_CAPTURE) & smp_valid;                  // R3
    assign last_smp     = (smp_cnt_q == (rec_len - REC_LEN_W'(1)));
    assign pack_clr     = start | ((state_q == ST_ARMED) & trig_rise);
    assign rec_cnt_next = rec_cnt_q + REC_CNT_W'(1);
    assign smp_arr      = {smp_ch1, smp_ch0};

    // Record and session sequencing (R2, R3, R7, R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_UNARMED;
            smp_cnt_q <= '0;
            rec_cnt_q <= '0;
            miss_q    <= '0;
        end else if (start) begin
            state_q   <= ST_ARMED;
            smp_cnt_q <= '0;
            rec_cnt_q <= '0;
            miss_q    <= '0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    if (trig_rise) begin
                        state_q   <= ST_CAPTURE;
                        smp_cnt_q <= '0;
                    end
                end
                ST_CAPTURE: begin
                    if (trig_rise && (miss_q != {MISS_W{1'b1}})) begin
                        miss_q <= miss_q + 1'b1;
                    end
                    if (accept) begin
                        if (last_smp) begin
                            smp_cnt_q <= '0;
                            rec_cnt_q <= rec_cnt_next;
                            state_q   <= (rec_cnt_next == rec_total) ? ST_DONE : ST_ARMED;
                        end else begin
                            smp_cnt_q <= smp_cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        trc_packer u_pack (
            .clk      (clk),
            .rst      (rst),
            .clear    (pack_clr),
            .accept   (accept),
            .last_in  (last_smp),
            .smp      (smp_arr[g]),
            .word_vld (word_vld[g]),
            .word_o   (pair.w[g])
        );
    end

    trc_pair_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push    (&word_vld),
        .pair_in (pair),
        .ovf_clr (ovf_clr),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_data  (m_data),
        .m_chan  (m_chan),
        .m_last  (m_last),
        .ovf     (ovf)
    );

    assign done       = (state_q == ST_DONE);
    assign rec_count  = rec_cnt_q;
    assign miss_count = miss_q;

endmodule

// File: rtl/trc_checker.sv
`timescale 1ns/1ps
module trc_checker #(
    parameter int REC_CNT_W = 20,
    parameter int MISS_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 ovf_clr,
    input logic                 m_valid,
    input logic                 m_ready,
    input logic [63:0]          m_data,
    input logic                 m_chan,
    input logic                 m_last,
    input logic                 done,
    input logic                 ovf,
    input logic [REC_CNT_W-1:0] rec_count,
    input logic [REC_CNT_W-1:0] rec_total,
    input logic [MISS_W-1:0]    miss_count
);

    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_chan) && $stable(m_last));

    a_r5_ch1_follows: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_ready && !m_chan |=> m_valid && m_chan);

    a_r5_ch0_first: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> !m_chan);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf && !ovf_clr |=> ovf);

    a_r9_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        ovf_clr |=> !ovf);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);

    a_r8_done_count: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> rec_count == rec_total);

    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> rec_count == '0 && miss_count == '0 && !done);

    a_r7_miss_step: assert property (@(posedge clk) disable iff (rst)
        $past(!start) && (miss_count != $past(miss_count)) |-> miss_count == $past(miss_count) + 1'b1);

endmodule

bind trig_rec_capture trc_checker #(
    .REC_CNT_W (REC_CNT_W),
    .MISS_W    (MISS_W)
) u_trc_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ovf_clr    (ovf_clr),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_chan     (m_chan),
    .m_last     (m_last),
    .done       (done),
    .ovf        (ovf),
    .rec_count  (rec_count),
    .rec_total  (rec_total),
    .miss_count (miss_count)
);

// File: tb/test_trig_rec_capture.sv
`timescale 1ns/1ps
module test_trig_rec_capture;
    import trc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] rec_len = '0;
    logic [19:0] rec_total = '0;
    logic        trig_in = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_ch0 = '0;
    logic [15:0] smp_ch1 = '0;
    logic        m_valid;
    logic        m_ready;
    logic [63:0] m_data;
    logic        m_chan;
    logic        m_last;
    logic        done;
    logic        ovf;
    logic [19:0] rec_count;
    logic [15:0] miss_count;

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 0;

    logic [15:0] exp0[$];
    logic [15:0] exp1[$];
    logic [63:0] got_d[$];
    logic        got_c[$];
    logic        got_l[$];

    always #5 clk = ~clk;

    trig_rec_capture i_trig_rec_capture (
        .clk(clk), .rst(rst), .start(start), .ovf_clr(ovf_clr),
        .rec_len(rec_len), .rec_total(rec_total), .trig_in(trig_in),
        .smp_valid(smp_valid), .smp_ch0(smp_ch0), .smp_ch1(smp_ch1),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_chan(m_chan), .m_last(m_last), .done(done), .ovf(ovf),
        .rec_count(rec_count), .miss_count(miss_count)
    );

    // Ready driver: 0 = stalled, 1 = always ready, 2 = random
    initial begin
        m_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0:       m_ready = 1'b0;
                1:       m_ready = 1'b1;
                default: m_ready = (($urandom % 8) != 0);
            endcase
        end
    end

    // Output monitor, sampled half a cycle before the transferring edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && m_valid && m_ready) begin
                got_d.push_back(m_data);
                got_c.push_back(m_chan);
                got_l.push_back(m_last);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (actual=timeout expected=finish)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic [15:0] q[$], input int k);
        logic [63:0] w;
        w = '0;
        for (int j = 0; j < LANES; j++) w[j*SMP_W +: SMP_W] = q[LANES*k + j];
        return w;
    endfunction

    task automatic pulse_start(input int len, input int total);
        @(posedge clk); #1;
        rec_len = 16'(len);
        rec_total = 20'(total);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic fire_trig();
        @(posedge clk); #1;
        trig_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 trig_in = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic stream(input int n, input int vpct);
        int sent;
        sent = 0;
        while (sent < n) begin
            @(posedge clk); #1;
            smp_valid = (($urandom % 100) < vpct);
            smp_ch0 = 16'($urandom);
            smp_ch1 = 16'($urandom);
            if (smp_valid) begin
                exp0.push_back(smp_ch0);
                exp1.push_back(smp_ch1);
                sent++;
            end
        end
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic drain();
        int idle;
        idle = 0;
        while (idle < 30) begin
            @(posedge clk);
            if (m_valid) idle = 0; else idle++;
        end
    endtask

    task automatic check_words(input int groups, input bit has_last, input string req);
        chk(got_d.size() == 2*groups, req, "word count", 64'(got_d.size()), 64'(2*groups));
        if (got_d.size() == 2*groups) begin
            for (int k = 0; k < groups; k++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [63:0] e;
                    bit el;
                    int i;
                    e  = (c == 0) ? exp_word(exp0, k) : exp_word(exp1, k);
                    el = has_last && (k == groups - 1);
                    i  = 2*k + c;
                    chk(got_d[i] == e, req, $sformatf("R4 data g%0d ch%0d", k, c), got_d[i], e);
                    chk(got_c[i] == c[0], "R5", "channel tag", 64'(got_c[i]), 64'(c));
                    chk(got_l[i] == el, "R5", "last flag", 64'(got_l[i]), 64'(el));
                end
            end
        end
        exp0.delete(); exp1.delete();
        got_d.delete(); got_c.delete(); got_l.delete();
    endtask

    initial begin
        int len;
        logic [63:0] held;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(m_valid == 1'b0, "R1", "m_valid", 64'(m_valid), 0);
        chk(done == 1'b0, "R1", "done", 64'(done), 0);
        chk(ovf == 1'b0, "R1", "ovf", 64'(ovf), 0);
        chk(rec_count == '0, "R1", "rec_count", 64'(rec_count), 0);
        chk(miss_count == '0, "R1", "miss_count", 64'(miss_count), 0);

        // R2: trigger before any start is ignored
        rdy_mode = 1;
        fire_trig();
        stream(16, 100);
        drain();
        check_words(0, 1'b0, "R2");
        chk(rec_count == '0, "R2", "rec_count unarmed", 64'(rec_count), 0);

        // R3/R4: directed record of 16 samples, continuous valid
        pulse_start(16, 5);
        fire_trig();
        stream(16, 100);
        drain();
        check_words(4, 1'b1, "R3");
        chk(rec_count == 20'd1, "R8", "rec_count after one", 64'(rec_count), 1);

        // Random lengths, gapped valid, random ready; session of two records
        for (int s = 0; s < 3; s++) begin
            len = 4 * (1 + ($urandom % 12));
            rdy_mode = 2;
            pulse_start(len, 2);
            for (int r = 0; r < 2; r++) begin
                fire_trig();
                stream(len, 70);
                drain();
                check_words(len / 4, 1'b1, "R3");
            end
            chk(done == 1'b1, "R8", "done at total", 64'(done), 1);
            chk(rec_count == 20'd2, "R8", "rec_count at total", 64'(rec_count), 2);
            // R8: triggers after done start nothing and are not counted
            fire_trig();
            stream(8, 100);
            drain();
            check_words(0, 1'b0, "R8");
            chk(rec_count == 20'd2, "R8", "rec_count after done", 64'(rec_count), 2);
            chk(miss_count == '0, "R8", "miss after done", 64'(miss_count), 0);
        end
        pulse_start(8, 10);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done cleared by start", 64'(done), 0);
        chk(rec_count == '0, "R8", "rec_count cleared", 64'(rec_count), 0);

        // R2: held trigger level gives a single record
        rdy_mode = 1;
        @(posedge clk); #1 trig_in = 1'b1;
        repeat (7) @(posedge clk);
        stream(8, 100);
        drain();
        check_words(2, 1'b1, "R2");
        stream(8, 100);
        drain();
        check_words(0, 1'b0, "R2");
        chk(rec_count == 20'd1, "R2", "one record from level", 64'(rec_count), 1);
        @(posedge clk); #1 trig_in = 1'b0;
        repeat (4) @(posedge clk);

        // R7: trigger during capture is missed, record continues intact
        pulse_start(40, 10);
        fire_trig();
        stream(12, 100);
        fire_trig();
        stream(28, 90);
        drain();
        check_words(10, 1'b1, "R7");
        chk(miss_count == 16'd1, "R7", "miss_count", 64'(miss_count), 1);
        chk(rec_count == 20'd1, "R7", "rec_count", 64'(rec_count), 1);

        // R9 overflow with stalled output; R6 hold while stalled
        pulse_start(40, 10);
        rdy_mode = 0;
        fire_trig();
        stream(40, 100);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ovf == 1'b1, "R9", "ovf set", 64'(ovf), 1);
        held = m_data;
        repeat (3) @(negedge clk);
        chk(m_valid == 1'b1, "R6", "valid held", 64'(m_valid), 1);
        chk(m_data == held, "R6", "data held", m_data, held);
        rdy_mode = 2;
        drain();
        check_words(8, 1'b0, "R9");
        chk(ovf == 1'b1, "R9", "ovf sticky", 64'(ovf), 1);
        @(posedge clk); #1 ovf_clr = 1'b1;
        @(posedge clk); #1 ovf_clr = 1'b0;
        @(negedge clk);
        chk(ovf == 1'b0, "R9", "ovf cleared", 64'(ovf), 0);
        rdy_mode = 1;
        fire_trig();
        stream(40, 100);
        drain();
        check_words(10, 1'b1, "R9");
        chk(rec_count == 20'd2, "R9", "records counted", 64'(rec_count), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule